// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Register

This block is one 32-bit register on a simple single-cycle register bus. It watches the ready levels of four clock sources and a pulse that reports a clock-security failure. It latches each event into a sticky interrupt flag. The four clock sources are a low-speed RC oscillator, an internal RC oscillator, an external crystal oscillator and the PLL. A clock-ready flag is taken only when the interrupt enable for that source is set. The security-failure flag is always taken. Software clears a flag by writing a 1 to its write-only clear bit.

The OR of the four ready flags drives one interrupt request line. The security-failure flag drives its own request line and has no enable bit. Reads return the flags and enables. Reserved positions and the clear positions read as zero. A bus write always loads the enable field and applies any clear bits in the same cycle. The flag positions themselves ignore write data.

The asynchronous active-low reset clears every field. Its release is synchronised inside the block, so the register only starts working a few cycles after the reset pin rises.

Top module: `clk_ready_irq_reg`

## Requirements
- R1: After reset, a read returns 0 and both `irq_ready_o` and `irq_secfail_o` are 0.
- R2: The enable field is loaded by every write that hits the register. Write data bit 8 enables the low-speed RC, bit 10 the internal RC, bit 11 the external oscillator and bit 12 the PLL. A read returns the enables at those same bit positions.
- R3: A ready flag sets only in a cycle in which its ready input is 1 after being 0 in the previous cycle and its enable bit is 1. Flag bit 0 is the low-speed RC, bit 2 the internal RC, bit 3 the external oscillator and bit 4 the PLL. A ready level that is held high does not set the flag again. A rise seen while the source is disabled is lost.
- R4: Writing 1 clears a flag. The clear bits are bit 16 for the low-speed RC, bit 18 for the internal RC, bit 19 for the external oscillator, bit 20 for the PLL and bit 23 for the security failure. Writing 0 to a clear bit leaves the flag unchanged.
- R5: The clear bits and all reserved bits (1, 5, 6, 9, 13 to 31 except the clear bits) always read as 0.
- R6: When a set event and a clear write for the same flag fall in one cycle, the flag ends up set.
- R7: `irq_ready_o` is 1 exactly when at least one of the four ready flags is 1.
- R8: A 1 on `secfail_i` sets flag bit 7 whatever the enables hold. `irq_secfail_o` follows that flag.
- R9: Write data in bits 0 to 7 never sets or clears a flag.
- R10: An access with `bus_sel_i` low, or with an address other than `REG_OFFSET`, changes nothing. A read in that case returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read |
| rdy_lowrc_i | input | 1 | Low-speed RC oscillator ready level |
| rdy_intrc_i | input | 1 | Internal RC oscillator ready level |
| rdy_xosc_i | input | 1 | External oscillator ready level |
| rdy_pll_i | input | 1 | PLL lock ready level |
| secfail_i | input | 1 | Clock-security failure pulse |
| irq_ready_o | output | 1 | OR of the four ready flags |
| irq_secfail_o | output | 1 | Security-failure request |

## Verification
Read data depends only on the current address and the register contents, so the bench checks it in the same cycle as the read, one time unit after the inputs change and before the clock edge. A ready rise, a security pulse or a write acts on the register at the next rising edge. Both request outputs are therefore due one unit after that edge, and every cycle the bench compares them there against its own model. The model is stepped at the same edge with the inputs that were driven before it. After the reset pin rises, the bench waits out the synchroniser delay with idle inputs before its first access.

// File: rtl/ckirq_pkg.sv
package ckirq_pkg;
  localparam int NSRC = 4;
  localparam int DW   = 32;

  // Source index: 0 low-speed RC, 1 internal RC, 2 external osc, 3 PLL
  localparam int FLAG_POS [NSRC] = '{0, 2, 3, 4};
  localparam int ENA_POS  [NSRC] = '{8, 10, 11, 12};
  localparam int CLR_POS  [NSRC] = '{16, 18, 19, 20};
  localparam int SEC_FLAG_POS = 7;
  localparam int SEC_CLR_POS  = 23;

  function automatic logic [DW-1:0] readable_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      m[FLAG_POS[i]] = 1'b1;
      m[ENA_POS[i]]  = 1'b1;
    end
    m[SEC_FLAG_POS] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] ready_clear_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[CLR_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ckirq_rst_sync.sv
module ckirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/ckirq_src_flag.sv
module ckirq_src_flag #(
  parameter bit EDGE_DET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic evt;
  logic flag_q;
  logic flag_d;

  generate
    if (EDGE_DET) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
      end
      assign evt = src_i & ~prev_q;
    end else begin : g_pulse
      assign evt = src_i;
    end
  endgenerate

  // set takes priority over clear
  always_comb begin
    flag_d = flag_q;
    if (clr_i)         flag_d = 1'b0;
    if (evt && arm_i)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/clk_ready_irq_reg.sv
module clk_ready_irq_reg
  import ckirq_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h04,
  parameter int               SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              rdy_lowrc_i,
  input  logic              rdy_intrc_i,
  input  logic              rdy_xosc_i,
  input  logic              rdy_pll_i,
  input  logic              secfail_i,
  output logic              irq_ready_o,
  output logic              irq_secfail_o
);
  logic            rst_core_n;
  logic            addr_hit;
  logic            wr_hit;
  logic            rd_hit;
  logic [NSRC-1:0] rdy_vec;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_vec;
  logic            sec_clr;
  logic            sec_flag;
  logic [DW-1:0]   rd_word;
  logic            unused_wdata;

  ckirq_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign rdy_vec  = {rdy_pll_i, rdy_xosc_i, rdy_intrc_i, rdy_lowrc_i};
  assign addr_hit = (bus_addr_i == REG_OFFSET);
  assign wr_hit   = bus_sel_i & bus_we_i & addr_hit;
  assign rd_hit   = bus_sel_i & ~bus_we_i & addr_hit;
  assign unused_wdata = ^bus_wdata_i;

  // enable field: next state and register
  always_comb begin
    en_d = en_q;
    if (wr_hit) begin
      for (int i = 0; i < NSRC; i++) en_d[i] = bus_wdata_i[ENA_POS[i]];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) en_q <= '0;
    else             en_q <= en_d;
  end

  // clear strobes
  always_comb begin
    for (int i = 0; i < NSRC; i++) clr_vec[i] = wr_hit & bus_wdata_i[CLR_POS[i]];
    sec_clr = wr_hit & bus_wdata_i[SEC_CLR_POS];
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      ckirq_src_flag #(.EDGE_DET(1'b1)) u_flag (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .src_i  (rdy_vec[g]),
        .arm_i  (en_q[g]),
        .clr_i  (clr_vec[g]),
        .flag_o (flag_vec[g])
      );
    end
  endgenerate

  ckirq_src_flag #(.EDGE_DET(1'b0)) u_sec_flag (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .src_i  (secfail_i),
    .arm_i  (1'b1),
    .clr_i  (sec_clr),
    .flag_o (sec_flag)
  );

  // read path
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      rd_word[FLAG_POS[i]] = flag_vec[i];
      rd_word[ENA_POS[i]]  = en_q[i];
    end
    rd_word[SEC_FLAG_POS] = sec_flag;
    bus_rdata_o = rd_hit ? rd_word : '0;
  end

  assign irq_ready_o   = |flag_vec;
  assign irq_secfail_o = sec_flag;
endmodule

// File: rtl/ckirq_chk.sv
module ckirq_chk
  import ckirq_pkg::*;
(
  input logic            clk,
  input logic            rst_core_n,
  input logic            wr_hit,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic [NSRC-1:0] rdy_vec,
  input logic            secfail_i,
  input logic            irq_ready_o,
  input logic            irq_secfail_o
);
  localparam logic [DW-1:0] RD_MASK  = readable_mask();
  localparam logic [DW-1:0] CLR_MASK = ready_clear_mask();

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rdata_o & ~RD_MASK) == '0);

  assert_rise_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq_ready_o) |-> $past(|rdy_vec));

  assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(irq_ready_o) |-> $past(wr_hit && ((bus_wdata_i & CLR_MASK) != '0)));

  assert_sec_set_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    secfail_i |=> irq_secfail_o);

  assert_sec_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(irq_secfail_o) |-> $past(wr_hit && bus_wdata_i[SEC_CLR_POS]));
endmodule

bind clk_ready_irq_reg ckirq_chk u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .wr_hit        (wr_hit),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .rdy_vec       (rdy_vec),
  .secfail_i     (secfail_i),
  .irq_ready_o   (irq_ready_o),
  .irq_secfail_o (irq_secfail_o)
);

// File: tb/clk_ready_irq_reg_tb_top.sv
module clk_ready_irq_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'h04;

  logic        clk;
  logic        rst_n;
  logic        sel, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  rdy;
  logic        sec;
  logic        irq_r, irq_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model
  logic [3:0] m_fl, m_en, m_prev;
  logic       m_sec;

  clk_ready_irq_reg dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rdy_lowrc_i(rdy[0]), .rdy_intrc_i(rdy[1]),
    .rdy_xosc_i(rdy[2]), .rdy_pll_i(rdy[3]),
    .secfail_i(sec), .irq_ready_o(irq_r), .irq_secfail_o(irq_s)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pack_word();
    logic [31:0] r;
    r = '0;
    r[0] = m_fl[0]; r[2] = m_fl[1]; r[3] = m_fl[2]; r[4] = m_fl[3];
    r[7] = m_sec;
    r[8] = m_en[0]; r[10] = m_en[1]; r[11] = m_en[2]; r[12] = m_en[3];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic hit;
    logic [3:0] clr, rise;
    hit  = sel && we && (addr == OFS);
    clr  = hit ? {wdata[20], wdata[19], wdata[18], wdata[16]} : 4'b0;
    rise = rdy & ~m_prev;
    m_fl  = (m_fl & ~clr) | (rise & m_en);
    m_sec = (m_sec & ~(hit & wdata[23])) | sec;
    if (hit) m_en = {wdata[12], wdata[11], wdata[10], wdata[8]};
    m_prev = rdy;
  endtask

  // one bus/input cycle; read data checked before the edge, requests after it
  task automatic cyc(input logic [3:0] r, input logic s, input logic sl, input logic w,
                     input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    rdy = r; sec = s; sel = sl; we = w; addr = a; wdata = d;
    #1;
    if (sl && !w) chk({req, " R5 R10 read"}, rdata, (a == OFS) ? pack_word() : 32'h0);
    @(posedge clk);
    model_step();
    #1;
    chk({req, " R7 irq_ready"}, {31'b0, irq_r}, {31'b0, |m_fl});
    chk({req, " R8 irq_secfail"}, {31'b0, irq_s}, {31'b0, m_sec});
  endtask

  task automatic wr(input logic [3:0] r, input logic s, input logic [31:0] d, input string req);
    cyc(r, s, 1'b1, 1'b1, OFS, d, req);
  endtask

  task automatic rd_exp(input logic [3:0] r, input logic [31:0] exp, input string req);
    cyc(r, 1'b0, 1'b1, 1'b0, OFS, 32'h0, req);
    n_tests++;
    if (pack_word() !== exp) begin
      n_fail++;
      $display("FAIL %s: model %h expected %h", req, pack_word(), exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] rr;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; sel = 0; we = 0; addr = 0; wdata = 0; rdy = 0; sec = 0;
    m_fl = 0; m_en = 0; m_prev = 0; m_sec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    #1;
    chk("R1 irq_ready", {31'b0, irq_r}, 32'h0);
    chk("R1 irq_secfail", {31'b0, irq_s}, 32'h0);
    rd_exp(4'b0000, 32'h0, "R1");

    // R2 enable load/readback
    wr(4'b0000, 0, 32'h0000_1D00, "R2");
    rd_exp(4'b0000, 32'h0000_1D00, "R2");
    // R5 all-ones write: clear and reserved bits read 0
    wr(4'b0000, 0, 32'hFFFF_FFFF, "R5");
    rd_exp(4'b0000, 32'h0000_1D00, "R5");

    // R3 rise with enable sets flag
    wr(4'b0001, 0, 32'h0000_1D00, "R3");
    rd_exp(4'b0001, 32'h0000_1D01, "R3");
    // R4 clear with ready held: no re-set from level
    wr(4'b0001, 0, 32'h0001_1D00, "R4");
    rd_exp(4'b0001, 32'h0000_1D00, "R3 R4");
    rd_exp(4'b0001, 32'h0000_1D00, "R3 level");

    // R8 security pulse independent of enables
    wr(4'b0001, 0, 32'h0000_0000, "R8");
    cyc(4'b0001, 1, 0, 0, OFS, 32'h0, "R8");
    rd_exp(4'b0001, 32'h0000_0080, "R8");
    // R4 zero clear bits no effect; R9 flag bits ignored
    wr(4'b0001, 0, 32'h0000_1D00, "R4 zero");
    rd_exp(4'b0001, 32'h0000_1D80, "R4 zero");
    wr(4'b0001, 0, 32'h0000_1DFF, "R9");
    rd_exp(4'b0001, 32'h0000_1D80, "R9");

    // R6 set wins over clear in the same cycle
    wr(4'b0011, 1, 32'h0084_1D00, "R6");
    rd_exp(4'b0011, 32'h0000_1D84, "R6");

    // R3 rise while disabled is lost
    wr(4'b0000, 0, 32'h009D_0000, "R3 dis");
    rd_exp(4'b0000, 32'h0000_0000, "R3 dis");
    cyc(4'b0100, 0, 0, 0, OFS, 32'h0, "R3 dis");
    wr(4'b0100, 0, 32'h0000_1D00, "R3 dis");
    rd_exp(4'b0100, 32'h0000_1D00, "R3 dis");

    // R10 misses and deselected writes
    cyc(4'b1100, 0, 0, 0, OFS, 32'h0, "R10 set");
    rd_exp(4'b1100, 32'h0000_1D10, "R10 set");
    cyc(4'b1100, 0, 1, 1, 8'h08, 32'h009D_0000, "R10 addr");
    cyc(4'b1100, 0, 0, 1, OFS, 32'h009D_0000, "R10 sel");
    cyc(4'b1100, 0, 1, 0, 8'h08, 32'h0, "R10 rd miss");
    rd_exp(4'b1100, 32'h0000_1D10, "R10");

    // constrained random
    rr = 4'b1100;
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] tg;
      logic s, sl, w;
      logic [7:0] a;
      logic [31:0] d;
      tg = 4'($urandom);
      for (int b = 0; b < 4; b++) if (($urandom % 4) == 0) rr[b] = ~rr[b];
      s  = (($urandom % 16) == 0);
      sl = (($urandom % 3) == 0);
      w  = 1'($urandom);
      a  = (($urandom % 8) == 0) ? 8'($urandom) : OFS;
      d  = $urandom;
      if (tg[0]) d[12:8] = 5'h1D;
      cyc(rr, s, sl, w, a, d, "R3 R4 R6 rnd");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule